// File: doc/BRIEF.md
# Split-Access 64-bit System Timer

This block keeps a 64-bit count of elapsed time and makes it reachable through a 32-bit APB slave port. Each cycle the count advances by one when its time base is enabled: the time base is either a one-cycle tick strobe supplied from outside (typically once per microsecond) or every system clock cycle, chosen by a control bit. A control pause bit and two per-processor debug-halt inputs can stop the count.

Because the bus is only half as wide as the count, both directions are made coherent. A write to the low-half write register only stages the value. The full count is loaded when the high-half write register is written, using the staged low half and the new high half together. A read of the low-half read register returns the live low half and captures the high half in the same cycle. A later read of the high-half read register returns that captured value, so a carry between the two reads cannot tear the result. Raw registers give the live halves with no side effect. A sticky lock bit blocks every later write until reset.

Top module: `sys_timer64`

## Requirements
- R1: After reset the count is 0, the source bit (0x38 bit 0) is 0, the pause bit (0x30 bit 0) is 0, the lock bit (0x34 bit 0) is 0, and the debug-enable register at 0x2C reads 0x6 (bit 1 for processor 0, bit 2 for processor 1, both set).
- R2: A write to offset 0x04 only stages the low half and leaves the count unchanged.
- R3: A write to offset 0x00 loads the count with {written data, staged low half} at that clock edge; in that cycle the load takes the place of any increment.
- R4: A read of offset 0x0C returns count bits 31:0 and captures bits 63:32 at the same edge; a read of offset 0x08 returns the captured value even when the count has since moved on.
- R5: Reads of offset 0x24 (bits 63:32) and 0x28 (bits 31:0) return the live count and do not change the captured high half.
- R6: With the source bit at 0 the count increases by one in each cycle where tick_i is high; with it at 1 it increases by one in every cycle.
- R7: While the pause bit (0x30 bit 0) is 1 the count holds its value.
- R8: The count holds while dbg_halt_i[0] is high and 0x2C bit 1 is set, or while dbg_halt_i[1] is high and 0x2C bit 2 is set; a halt input whose enable bit is clear has no effect.
- R9: Writing 1 to 0x34 bit 0 sets the lock; once set it stays set until reset, and every later write (count, staging, control and the lock itself) is ignored.
- R10: The count wraps from all ones to zero.
- R11: Reads of unmapped offsets return 0; pready is always 1 and pslverr always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error, tied low |
| tick_i | input | 1 | Time-base strobe, one cycle wide |
| dbg_halt_i | input | 2 | Per-processor debug-halt levels |

## Verification
Writes take effect at the clock edge that ends the APB access phase, so a read whose setup phase starts right after that edge sees one more increment in clock-source mode. That is why a staged load followed by an immediate low read expects the loaded value plus one. Read data is combinational during the access phase and is sampled at the falling edge of that cycle. Two back-to-back reads are therefore two edges apart, and the expected difference is 2 when counting and 0 when halted. Tick-source tests hold tick_i low except for single-cycle pulses, so expected values are exact.

// File: rtl/sys_timer64_pkg.sv
package sys_timer64_pkg;
    localparam int unsigned HALF_W  = 32;
    localparam int unsigned CNT_W   = 2 * HALF_W;
    localparam int unsigned NUM_DBG = 2;
    localparam int unsigned OFS_W   = 8;

    // Register offsets (software decodes these)
    localparam logic [OFS_W-1:0] OFS_HI_WR  = 8'h00;
    localparam logic [OFS_W-1:0] OFS_LO_WR  = 8'h04;
    localparam logic [OFS_W-1:0] OFS_HI_RD  = 8'h08;
    localparam logic [OFS_W-1:0] OFS_LO_RD  = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_RAW_HI = 8'h24;
    localparam logic [OFS_W-1:0] OFS_RAW_LO = 8'h28;
    localparam logic [OFS_W-1:0] OFS_DBG_EN = 8'h2C;
    localparam logic [OFS_W-1:0] OFS_PAUSE  = 8'h30;
    localparam logic [OFS_W-1:0] OFS_LOCK   = 8'h34;
    localparam logic [OFS_W-1:0] OFS_SRC    = 8'h38;

    typedef struct packed {
        logic [HALF_W-1:0]  stage_lo;
        logic [HALF_W-1:0]  hi_hold;
        logic               src_clk;
        logic               pause;
        logic [NUM_DBG-1:0] dbg_en;
        logic               lock;
    } ctl_regs_t;
endpackage

// File: rtl/sys_timer64_gate.sv
module sys_timer64_gate
    import sys_timer64_pkg::*;
(
    input  logic               src_clk,
    input  logic               pause,
    input  logic [NUM_DBG-1:0] dbg_en,
    input  logic [NUM_DBG-1:0] dbg_halt,
    input  logic               tick,
    output logic               cnt_en
);
    logic [NUM_DBG-1:0] halt_vec;

    for (genvar g = 0; g < NUM_DBG; g++) begin : g_halt
        assign halt_vec[g] = dbg_en[g] & dbg_halt[g];
    end

    always_comb begin
        cnt_en = (src_clk | tick) & ~pause & ~(|halt_vec);
    end
endmodule

// File: rtl/sys_timer64_count.sv
module sys_timer64_count
    import sys_timer64_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             cnt_en,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ld_en) begin
            cnt_d = ld_val;
        end else if (cnt_en) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/sys_timer64_regs.sv
module sys_timer64_regs
    import sys_timer64_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [HALF_W-1:0]  pwdata,
    input  logic [CNT_W-1:0]   cnt_i,
    output logic [HALF_W-1:0]  prdata,
    output logic               ld_en,
    output logic [CNT_W-1:0]   ld_val,
    output logic               src_clk,
    output logic               pause,
    output logic [NUM_DBG-1:0] dbg_en,
    output logic               lock,
    output logic [HALF_W-1:0]  hi_hold
);
    ctl_regs_t r_d, r_q;
    logic      wr_acc, rd_acc;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [OFS_W-1:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    always_comb begin
        wr_acc = psel & penable & pwrite & ~r_q.lock;
        rd_acc = psel & penable & ~pwrite;
        r_d    = r_q;
        ld_en  = 1'b0;
        ld_val = {pwdata, r_q.stage_lo};

        if (wr_acc) begin
            if (hit(paddr, OFS_LO_WR)) r_d.stage_lo = pwdata;
            if (hit(paddr, OFS_HI_WR)) ld_en        = 1'b1;
            if (hit(paddr, OFS_DBG_EN)) r_d.dbg_en  = pwdata[NUM_DBG:1];
            if (hit(paddr, OFS_PAUSE)) r_d.pause    = pwdata[0];
            if (hit(paddr, OFS_SRC)) r_d.src_clk    = pwdata[0];
            if (hit(paddr, OFS_LOCK)) r_d.lock      = r_q.lock | pwdata[0];
        end
        if (rd_acc && hit(paddr, OFS_LO_RD)) begin
            r_d.hi_hold = cnt_i[CNT_W-1:HALF_W];
        end
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            if (hit(paddr, OFS_LO_RD))  prdata = cnt_i[HALF_W-1:0];
            if (hit(paddr, OFS_HI_RD))  prdata = r_q.hi_hold;
            if (hit(paddr, OFS_RAW_LO)) prdata = cnt_i[HALF_W-1:0];
            if (hit(paddr, OFS_RAW_HI)) prdata = cnt_i[CNT_W-1:HALF_W];
            if (hit(paddr, OFS_DBG_EN)) prdata = HALF_W'({r_q.dbg_en, 1'b0});
            if (hit(paddr, OFS_PAUSE))  prdata = HALF_W'(r_q.pause);
            if (hit(paddr, OFS_LOCK))   prdata = HALF_W'(r_q.lock);
            if (hit(paddr, OFS_SRC))    prdata = HALF_W'(r_q.src_clk);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.dbg_en   <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign src_clk = r_q.src_clk;
    assign pause   = r_q.pause;
    assign dbg_en  = r_q.dbg_en;
    assign lock    = r_q.lock;
    assign hi_hold = r_q.hi_hold;
endmodule

// File: rtl/sys_timer64.sv
module sys_timer64
    import sys_timer64_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [HALF_W-1:0]  pwdata,
    output logic [HALF_W-1:0]  prdata,
    output logic               pready,
    output logic               pslverr,
    input  logic               tick_i,
    input  logic [NUM_DBG-1:0] dbg_halt_i
);
    logic [CNT_W-1:0]   cnt_w;
    logic [CNT_W-1:0]   ld_val_w;
    logic               ld_en_w;
    logic               cnt_en_w;
    logic               src_clk_w;
    logic               pause_w;
    logic [NUM_DBG-1:0] dbg_en_w;
    logic               lock_w;
    logic [HALF_W-1:0]  hi_hold_w;

    sys_timer64_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .cnt_i   (cnt_w),
        .prdata  (prdata),
        .ld_en   (ld_en_w),
        .ld_val  (ld_val_w),
        .src_clk (src_clk_w),
        .pause   (pause_w),
        .dbg_en  (dbg_en_w),
        .lock    (lock_w),
        .hi_hold (hi_hold_w)
    );

    sys_timer64_gate u_gate (
        .src_clk  (src_clk_w),
        .pause    (pause_w),
        .dbg_en   (dbg_en_w),
        .dbg_halt (dbg_halt_i),
        .tick     (tick_i),
        .cnt_en   (cnt_en_w)
    );

    sys_timer64_count u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (ld_en_w),
        .ld_val (ld_val_w),
        .cnt_en (cnt_en_w),
        .cnt_o  (cnt_w)
    );

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
endmodule

// File: rtl/sys_timer64_chk.sv
module sys_timer64_chk
    import sys_timer64_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic              pready,
    input logic              pslverr,
    input logic              lock,
    input logic              ld_en,
    input logic [CNT_W-1:0]  ld_val,
    input logic              cnt_en,
    input logic [CNT_W-1:0]  cnt,
    input logic [HALF_W-1:0] hi_hold
);
    logic rd_lo;
    assign rd_lo = psel && penable && !pwrite && (paddr == ADDR_W'(OFS_LO_RD));

    a_r11_apb_resp: assert property (@(posedge clk) disable iff (!rst_n)
        pready && !pslverr);

    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

    a_r9_no_load_locked: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> !ld_en);

    a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> cnt == $past(ld_val));

    a_r6_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !ld_en) |=> cnt == $past(cnt) + CNT_W'(1));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !ld_en) |=> $stable(cnt));

    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> hi_hold == $past(cnt[CNT_W-1:HALF_W]));
endmodule

bind sys_timer64 sys_timer64_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pready  (pready),
    .pslverr (pslverr),
    .lock    (lock_w),
    .ld_en   (ld_en_w),
    .ld_val  (ld_val_w),
    .cnt_en  (cnt_en_w),
    .cnt     (cnt_w),
    .hi_hold (hi_hold_w)
);

// File: tb/sys_timer64_bench.sv
module sys_timer64_bench;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              psel = 1'b0;
    logic              penable = 1'b0;
    logic              pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [31:0]       pwdata = '0;
    logic [31:0]       prdata;
    logic              pready;
    logic              pslverr;
    logic              tick_i = 1'b0;
    logic [1:0]        dbg_halt_i = 2'b00;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit chk_arm = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    sys_timer64 #(.ADDR_W(ADDR_W)) u_sys_timer64 (
        .clk        (clk),
        .rst_n      (rst_n),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .prdata     (prdata),
        .pready     (pready),
        .pslverr    (pslverr),
        .tick_i     (tick_i),
        .dbg_halt_i (dbg_halt_i)
    );

    // Monitor: compares access-phase read data against the queued expectation
    always @(negedge clk) begin
        if (rst_n && psel && penable) begin
            total++;
            if (!(pready === 1'b1 && pslverr === 1'b0)) begin
                bad++;
                $display("FAIL R11 response: pready=%b pslverr=%b expected 1/0", pready, pslverr);
            end
            if (!pwrite && chk_arm) begin
                logic [31:0] e;
                string t;
                total++;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (prdata !== e) begin
                    bad++;
                    $display("FAIL %s addr=%h: actual=%h expected=%h", t, paddr, prdata, e);
                end
            end
        end
    end

    // All tasks start just after a rising edge
    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd_get(input logic [7:0] a, output logic [31:0] v);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0; chk_arm = 0;
        @(posedge clk); #1;
        penable = 1'b1;
        @(negedge clk);
        v = prdata;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0; chk_arm = 1;
        @(posedge clk); #1;
        penable = 1'b1;
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; chk_arm = 0;
    endtask

    task automatic pulse_tick();
        tick_i = 1'b1;
        @(posedge clk); #1;
        tick_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] hv;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset state
        chk_rd(8'h28, 32'h0, "R1 raw low");
        chk_rd(8'h24, 32'h0, "R1 raw high");
        chk_rd(8'h2C, 32'h6, "R1 debug enables");
        chk_rd(8'h38, 32'h0, "R1 source");
        chk_rd(8'h30, 32'h0, "R1 pause");
        chk_rd(8'h34, 32'h0, "R1 lock");
        // R11 unmapped
        chk_rd(8'h40, 32'h0, "R11 unmapped");
        chk_rd(8'h10, 32'h0, "R11 unmapped");

        // R2 staging only
        apb_wr(8'h04, 32'hDEAD_BEEF);
        chk_rd(8'h28, 32'h0, "R2 low unchanged");
        chk_rd(8'h24, 32'h0, "R2 high unchanged");
        // R3 commit
        apb_wr(8'h00, 32'h0000_0005);
        chk_rd(8'h24, 32'h5, "R3 high loaded");
        chk_rd(8'h28, 32'hDEAD_BEEF, "R3 low from stage");

        // R4/R5 coherent read across a carry
        apb_wr(8'h04, 32'hFFFF_FFFF);
        apb_wr(8'h00, 32'h0000_0005);
        chk_rd(8'h0C, 32'hFFFF_FFFF, "R4 low read");
        pulse_tick();
        chk_rd(8'h24, 32'h6, "R5 raw high live");
        chk_rd(8'h08, 32'h5, "R4 captured high");
        chk_rd(8'h28, 32'h0, "R6 tick counted");

        // R10 wrap
        apb_wr(8'h04, 32'hFFFF_FFFF);
        apb_wr(8'h00, 32'hFFFF_FFFF);
        chk_rd(8'h24, 32'hFFFF_FFFF, "R10 all ones");
        pulse_tick();
        chk_rd(8'h0C, 32'h0, "R10 wrapped low");
        chk_rd(8'h08, 32'h0, "R10 wrapped high");

        // R6 tick source idle, then clock source
        rd_get(8'h28, v);
        chk_rd(8'h28, v, "R6 no tick no count");
        apb_wr(8'h38, 32'h1);
        rd_get(8'h28, v);
        chk_rd(8'h28, v + 32'd2, "R6 clock source");

        // R3 load beats increment
        apb_wr(8'h04, 32'h0000_0100);
        apb_wr(8'h00, 32'h0000_0007);
        chk_rd(8'h28, 32'h0000_0101, "R3 load priority");

        // R7 pause
        apb_wr(8'h30, 32'h1);
        rd_get(8'h28, v);
        chk_rd(8'h28, v, "R7 paused");
        chk_rd(8'h30, 32'h1, "R7 pause readback");
        apb_wr(8'h30, 32'h0);
        rd_get(8'h28, v);
        chk_rd(8'h28, v + 32'd2, "R7 resumed");

        // R8 debug pause
        dbg_halt_i = 2'b01;
        rd_get(8'h28, v);
        chk_rd(8'h28, v, "R8 proc0 halt");
        apb_wr(8'h2C, 32'h4);
        rd_get(8'h28, v);
        chk_rd(8'h28, v + 32'd2, "R8 proc0 disabled");
        chk_rd(8'h2C, 32'h4, "R8 enable readback");
        dbg_halt_i = 2'b10;
        rd_get(8'h28, v);
        chk_rd(8'h28, v, "R8 proc1 halt");
        dbg_halt_i = 2'b00;
        apb_wr(8'h2C, 32'h6);

        // R9 lock
        apb_wr(8'h38, 32'h0);
        apb_wr(8'h34, 32'h1);
        chk_rd(8'h34, 32'h1, "R9 lock set");
        rd_get(8'h28, v);
        rd_get(8'h24, hv);
        apb_wr(8'h04, 32'h55);
        apb_wr(8'h00, 32'h66);
        chk_rd(8'h28, v, "R9 low write ignored");
        chk_rd(8'h24, hv, "R9 high write ignored");
        apb_wr(8'h38, 32'h1);
        chk_rd(8'h38, 32'h0, "R9 source write ignored");
        chk_rd(8'h28, v, "R9 still tick source");
        apb_wr(8'h34, 32'h0);
        chk_rd(8'h34, 32'h1, "R9 lock sticky");
        apb_wr(8'h30, 32'h1);
        chk_rd(8'h30, 32'h0, "R9 pause write ignored");

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard: %0d expected reads left, expected 0", exp_q.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule